// File: doc/BRIEF.md
# Configurable Aspect-Ratio Block RAM

A synchronous single-port memory holding 2,048 bits, arranged as 128 rows of 16 bits. The array can be used as 128x16, 256x8, 512x4, 1,024x2 or 2,048x1. In the narrower shapes, the address bits above the row index pick a lane inside a row. Writes and reads are timed only by the clock edge: the block forms its own write strobe from a write request, so callers only meet setup and hold at the clock.

A page decoder lets several instances share one address space and one output. Each instance compares the page-address bits with its own page ID. Only the matching instance writes, and only that instance raises its drive-enable and puts data out. Every other instance presents zero, so the outputs are combined with an OR. Instances that share an address but have different data bits give a wider word.

Top module: `cfg_bram`

## Requirements
- R1: `mode_i` selects the shape: 0 = 128x16, 1 = 256x8, 2 = 512x4, 3 = 1,024x2, 4 = 2,048x1. Codes 5 to 7 act as 2,048x1.
- R2: The row is `addr_i[6:0]`. With k = the mode code (capped at 4), the lane is `addr_i[6+k:7]` and has 16>>k bits. Lane 0 holds row bits [lane width-1:0]. Address bits above bit 6+k are ignored.
- R3: A write happens on the rising clock edge when `wr_i` is 1 and the page matches. It stores the low lane-width bits of `wdata_i` into the selected lane, and leaves the other bits of the row unchanged.
- R4: Read data appears on `rdata_o` one clock after the address. It is the selected lane, right-aligned, with zeros above.
- R5: When a read and a write hit the same address in the same cycle, the read returns the data held before the write.
- R6: `drive_o` is 1 in the cycle after `page_addr_i == page_id_i` and 0 in the cycle after a mismatch. A write with a mismatched page leaves the memory unchanged.
- R7: While `drive_o` is 0, `rdata_o` is all zeros.
- R8: With four instances that have page IDs 0 to 3 and share all other inputs, exactly one instance asserts drive-enable for every page address. The OR of their outputs returns that instance's data.
- R9: `mode_i` is captured only in cycles with `wr_i` low, and it applies from the next cycle. A write uses the mode captured earlier.
- R10: Stored bits keep their physical row and bit position across a mode change.
- R11: While reset is held, `rdata_o` and `drive_o` are 0, and the mode is 128x16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Shape select |
| addr_i | input | 11 | Word address inside the page |
| page_addr_i | input | PAGE_W | High address bits for the page decoder |
| page_id_i | input | PAGE_W | This instance's page number |
| wr_i | input | 1 | Write request |
| wdata_i | input | 16 | Write data, lane-width bits used |
| rdata_o | output | 16 | Registered read data, zero when not driving |
| drive_o | output | 1 | This instance owns the shared output |

## Verification
Two kinds of coincidence are provoked. The first is a read and a write to the same address in one cycle. The bench judges it by expecting the data held before the write, then reading the new value in the following cycle. The second is a change of `mode_i` presented in the same cycle as a write. The bench checks that the write still follows the earlier shape and that the new shape only applies once the request has dropped. All expected values come from a bit-level reference of the 128x16 array.

// File: rtl/cfg_bram_pkg.sv
package cfg_bram_pkg;
  localparam int ROW_W   = 16;
  localparam int ROWS    = 128;
  localparam int ROW_AW  = $clog2(ROWS);
  localparam int LANE_LG = $clog2(ROW_W);
  localparam int AW      = ROW_AW + LANE_LG;
  localparam int MODE_W  = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_X16 = 3'd0,
    MODE_X8  = 3'd1,
    MODE_X4  = 3'd2,
    MODE_X2  = 3'd3,
    MODE_X1  = 3'd4
  } mode_e;
endpackage

// File: rtl/cfg_bram_lane_map.sv
module cfg_bram_lane_map
  import cfg_bram_pkg::*;
(
  input  logic [MODE_W-1:0]  mode_i,
  input  logic [AW-1:0]      addr_i,
  output logic [ROW_AW-1:0]  row_o,
  output logic [LANE_LG-1:0] shift_o,
  output logic [ROW_W-1:0]   lmask_o,
  output logic [ROW_W-1:0]   bmask_o
);
  logic [MODE_W-1:0]    k;
  logic [LANE_LG:0]     lw;
  logic [LANE_LG:0]     sel;
  logic [LANE_LG-1:0]   lane;
  logic [2*LANE_LG+1:0] prod;
  logic [ROW_W:0]       ones;

  always_comb begin
    k       = (mode_i > MODE_X1) ? MODE_X1 : mode_i;
    lw      = (LANE_LG+1)'(ROW_W) >> k;
    sel     = ((LANE_LG+1)'(1) << k) - (LANE_LG+1)'(1);
    lane    = addr_i[AW-1:ROW_AW] & sel[LANE_LG-1:0];
    prod    = {(LANE_LG+2)'(0), lane} * {(LANE_LG+1)'(0), lw};
    shift_o = prod[LANE_LG-1:0];
    ones    = ((ROW_W+1)'(1) << lw) - (ROW_W+1)'(1);
    lmask_o = ones[ROW_W-1:0];
    bmask_o = lmask_o << shift_o;
    row_o   = addr_i[ROW_AW-1:0];
  end

  // R2: lane mask width follows the mode
  always_comb begin
    a_r2_lane_width: assert ($countones(bmask_o) == 32'(lw))
      else $error("lane mask width mismatch");
  end
endmodule

// File: rtl/cfg_bram_array.sv
module cfg_bram_array #(
  parameter int ROWS  = 128,
  parameter int W     = 16,
  localparam int RAW  = $clog2(ROWS)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [RAW-1:0] row_i,
  input  logic [W-1:0]   bmask_i,
  input  logic [W-1:0]   wval_i,
  output logic [W-1:0]   rrow_o
);
  logic [W-1:0] mem_q [ROWS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[row_i] <= (mem_q[row_i] & ~bmask_i) | (wval_i & bmask_i);
  end

  // read returns pre-write contents
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rrow_o <= '0;
    else         rrow_o <= mem_q[row_i];
  end
endmodule

// File: rtl/cfg_bram_page_gate.sv
module cfg_bram_page_gate #(
  parameter int PAGE_W = 2,
  parameter int W      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PAGE_W-1:0] page_addr_i,
  input  logic [PAGE_W-1:0] page_id_i,
  input  logic [W-1:0]      data_i,
  output logic              match_o,
  output logic              drive_o,
  output logic [W-1:0]      data_o
);
  assign match_o = (page_addr_i == page_id_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drive_o <= 1'b0;
    else         drive_o <= match_o;
  end

  // AND gating so outputs combine by OR, never floating
  assign data_o = data_i & {W{drive_o}};

  a_r6_drive_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (page_addr_i == page_id_i) |=> drive_o);
  a_r6_drive_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (page_addr_i != page_id_i) |=> !drive_o);
endmodule

// File: rtl/cfg_bram.sv
module cfg_bram
  import cfg_bram_pkg::*;
#(
  parameter int PAGE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [PAGE_W-1:0] page_addr_i,
  input  logic [PAGE_W-1:0] page_id_i,
  input  logic              wr_i,
  input  logic [ROW_W-1:0]  wdata_i,
  output logic [ROW_W-1:0]  rdata_o,
  output logic              drive_o
);
  logic [MODE_W-1:0]  mode_q;
  logic [ROW_AW-1:0]  row;
  logic [LANE_LG-1:0] shift, shift_q;
  logic [ROW_W-1:0]   lmask, lmask_q, bmask, rrow, lane_data;
  logic               match;

  // mode only moves while no write is requested
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mode_q <= MODE_X16;
    else if (!wr_i) mode_q <= mode_i;
  end

  cfg_bram_lane_map u_map (
    .mode_i  (mode_q),
    .addr_i  (addr_i),
    .row_o   (row),
    .shift_o (shift),
    .lmask_o (lmask),
    .bmask_o (bmask)
  );

  cfg_bram_array #(.ROWS(ROWS), .W(ROW_W)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_i & match),
    .row_i   (row),
    .bmask_i (bmask),
    .wval_i  (wdata_i << shift),
    .rrow_o  (rrow)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      lmask_q <= '0;
    end else begin
      shift_q <= shift;
      lmask_q <= lmask;
    end
  end

  assign lane_data = (rrow >> shift_q) & lmask_q;

  cfg_bram_page_gate #(.PAGE_W(PAGE_W), .W(ROW_W)) u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .page_addr_i (page_addr_i),
    .page_id_i   (page_id_i),
    .data_i      (lane_data),
    .match_o     (match),
    .drive_o     (drive_o),
    .data_o      (rdata_o)
  );

  // R4: nothing above the lane width chosen for the previous address
  a_r4_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~lmask_q) == '0);
  // R9: held mode during a write request
  a_r9_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && mode_i != mode_q) |=> $stable(mode_q));
endmodule

// File: tb/cfg_bram_tb.sv
module cfg_bram_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  mode_i = 3'd0;
  logic [10:0] addr_i = '0;
  logic [1:0]  page_addr_i = 2'd1;
  logic [1:0]  page_id_i = 2'd1;
  logic        wr_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        drive_o;

  int total = 0;
  int bad = 0;
  logic [15:0] ref_mem [128];
  logic [2:0]  cur_mode = 3'd0;

  always #10 clk_i = ~clk_i;

  cfg_bram #(.PAGE_W(2)) u_dut (
    .clk_i, .rst_ni, .mode_i, .addr_i, .page_addr_i, .page_id_i,
    .wr_i, .wdata_i, .rdata_o, .drive_o
  );

  logic [15:0] stk_rd [4];
  logic [3:0]  stk_drv;
  logic [15:0] stk_bus;
  for (genvar g = 0; g < 4; g++) begin : g_stk
    cfg_bram #(.PAGE_W(2)) u_stk (
      .clk_i, .rst_ni, .mode_i, .addr_i, .page_addr_i,
      .page_id_i (2'(g)),
      .wr_i, .wdata_i,
      .rdata_o (stk_rd[g]),
      .drive_o (stk_drv[g])
    );
  end
  assign stk_bus = stk_rd[0] | stk_rd[1] | stk_rd[2] | stk_rd[3];

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int kk(logic [2:0] m);
    return (m > 3'd4) ? 4 : int'(m);
  endfunction

  function automatic logic [15:0] ref_read(logic [2:0] m, logic [10:0] a);
    int k = kk(m);
    int lw = 16 >> k;
    int lane = int'(a >> 7) & ((1 << k) - 1);
    logic [15:0] v = '0;
    for (int b = 0; b < lw; b++) v[b] = ref_mem[a[6:0]][lane*lw + b];
    return v;
  endfunction

  task automatic ref_write(logic [2:0] m, logic [10:0] a, logic [15:0] d);
    int k = kk(m);
    int lw = 16 >> k;
    int lane = int'(a >> 7) & ((1 << k) - 1);
    for (int b = 0; b < lw; b++) ref_mem[a[6:0]][lane*lw + b] = d[b];
  endtask

  task automatic set_mode(logic [2:0] m);
    @(negedge clk_i);
    mode_i = m; wr_i = 1'b0;
    cur_mode = m;
  endtask

  task automatic do_write(logic [10:0] a, logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1; page_addr_i = page_id_i;
    ref_write(cur_mode, a, d);
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic do_read(string req, logic [10:0] a);
    @(negedge clk_i);
    addr_i = a; wr_i = 1'b0; page_addr_i = page_id_i;
    @(negedge clk_i);
    check(req, rdata_o, ref_read(cur_mode, a));
  endtask

  task automatic t_reset();
    check("R11 rdata", rdata_o, 16'h0);
    check("R11 drive", {15'h0, drive_o}, 16'h1 & 16'h0);
  endtask

  task automatic t_modes();
    for (int m = 0; m < 5; m++) begin
      int depth = 128 << m;
      logic [10:0] list [4];
      set_mode(3'(m));
      list[0] = 11'(0); list[1] = 11'(depth - 1);
      list[2] = 11'(depth / 2 + 3); list[3] = 11'(depth / 3);
      for (int i = 0; i < 4; i++) do_write(list[i], 16'(32'hA5C3 ^ (m * 4099 + i * 777)));
      for (int i = 0; i < 4; i++) do_read("R3 R4 mode readback", list[i]);
    end
  endtask

  task automatic t_ignored_high_bits();
    set_mode(3'd1);
    do_write(11'h005, 16'hBEEF);
    do_read("R2 high bit ignored", 11'h405);
    check("R2 lane0 value", ref_read(3'd1, 11'h005), 16'h00EF);
  endtask

  task automatic t_mode_persist();
    set_mode(3'd0);
    do_write(11'h011, 16'h8421);
    set_mode(3'd4);
    for (int l = 0; l < 16; l++) do_read("R10 bit position", 11'((l << 7) | 16'h11));
    set_mode(3'd2);
    do_read("R10 nibble 3", 11'((3 << 7) | 16'h11));
  endtask

  task automatic t_invalid_mode();
    set_mode(3'd7);
    do_write(11'h7FF, 16'h0001);
    do_read("R1 code 7 as x1", 11'h7FF);
    check("R1 ref row bit", ref_mem[127][15] ? 16'h1 : 16'h0, 16'h1);
  endtask

  task automatic t_mode_during_write();
    set_mode(3'd0);
    @(negedge clk_i);
    addr_i = 11'h020; wdata_i = 16'h1234; wr_i = 1'b1; mode_i = 3'd1;
    ref_write(3'd0, 11'h020, 16'h1234);
    @(negedge clk_i);
    wr_i = 1'b0;
    cur_mode = 3'd1;
    do_read("R9 new mode after write lane1", 11'h0A0);
    do_read("R9 new mode after write lane0", 11'h020);
  endtask

  task automatic t_read_during_write();
    logic [15:0] old;
    set_mode(3'd0);
    do_write(11'h030, 16'h5555);
    old = ref_read(3'd0, 11'h030);
    @(negedge clk_i);
    addr_i = 11'h030; wdata_i = 16'hAAAA; wr_i = 1'b1;
    ref_write(3'd0, 11'h030, 16'hAAAA);
    @(negedge clk_i);
    wr_i = 1'b0;
    check("R5 old data", rdata_o, old);
    @(negedge clk_i);
    check("R5 new data next", rdata_o, 16'hAAAA);
  endtask

  task automatic t_page_mismatch();
    set_mode(3'd0);
    do_write(11'h040, 16'h0F0F);
    @(negedge clk_i);
    addr_i = 11'h040; wdata_i = 16'hFFFF; wr_i = 1'b1; page_addr_i = 2'd2;
    @(negedge clk_i);
    wr_i = 1'b0;
    check("R6 drive off", {15'h0, drive_o}, 16'h0);
    check("R7 zero out", rdata_o, 16'h0);
    do_read("R6 write blocked", 11'h040);
    check("R6 drive on", {15'h0, drive_o}, 16'h1);
  endtask

  task automatic t_stack();
    set_mode(3'd0);
    for (int p = 0; p < 4; p++) begin
      @(negedge clk_i);
      addr_i = 11'h055; wdata_i = 16'(16'h1000 * (p + 1) + p); wr_i = 1'b1; page_addr_i = 2'(p);
      @(negedge clk_i);
      wr_i = 1'b0;
    end
    for (int p = 0; p < 4; p++) begin
      @(negedge clk_i);
      addr_i = 11'h055; page_addr_i = 2'(p);
      @(negedge clk_i);
      check("R8 one driver", 16'($countones(stk_drv)), 16'h1);
      check("R8 right driver", {12'h0, stk_drv}, 16'(1 << p));
      check("R8 bus data", stk_bus, 16'(16'h1000 * (p + 1) + p));
    end
    page_addr_i = page_id_i;
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int r = 0; r < 128; r++) ref_mem[r] = 16'h0;
    #5;
    t_reset();
    // known contents so reference matches
    @(negedge clk_i);
    rst_ni = 1'b1;
    set_mode(3'd0);
    for (int r = 0; r < 128; r++) do_write(11'(r), 16'h0);
    t_modes();
    t_ignored_high_bits();
    t_mode_persist();
    t_invalid_mode();
    t_mode_during_write();
    t_read_during_write();
    t_page_mismatch();
    t_stack();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule